// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Unit

The block lets two CPUs, called left and right, share one word-addressed memory. Each side has its own independent port. The address space is 13 bits wide (0x0000 to 0x1FFF) and each word is 16 bits. The two top addresses are not ordinary storage. Each acts as a message slot owned by one side: 0x1FFE belongs to the left port and 0x1FFF belongs to the right port.

To signal its partner, a CPU writes a word into the partner's slot. That write pulls the partner's active-low interrupt line low. The partner reads its own slot to collect the message, and that read releases its interrupt. Any other access has no effect on the interrupts. Access arbitration and semaphores are not part of this block.

All other addresses reach a plain synchronous storage array. To keep the default build small, the array decodes only the low `STORE_AW` address bits, so higher addresses alias onto it.

Top module: `dpm_mailbox_top`

## Requirements
- R1: While reset is held (synchronous, active-low), both `l_int_n` and `r_int_n` are high in the cycle after each reset edge.
- R2: Read data appears on `*_rdata` in the cycle after the read is issued. A word written at an ordinary address by either port can be read back by either port.
- R3: A left-port write to 0x1FFF stores the data in the right slot and drives `r_int_n` low from the next cycle.
- R4: A right-port write to 0x1FFE stores the data in the left slot and drives `l_int_n` low from the next cycle.
- R5: A port that reads its own slot gets the stored word, and its own interrupt output returns high from the next cycle.
- R6: A port that reads the opposite port's slot gets the stored word and clears no interrupt.
- R7: A port's write to its own slot is ignored. The slot value and both interrupt outputs are unchanged.
- R8: If a set and a clear of the same interrupt fall in the same cycle, the interrupt stays asserted.
- R9: A read in the same cycle as a write to the same location returns the previous contents. When both ports write the same ordinary address in one cycle, the right port's data is kept.
- R10: At ordinary addresses (below 0x1FFE), only address bits [STORE_AW-1:0] select the word (default STORE_AW = 9). For example, 0x0205 and 0x0005 name the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_en | input | 1 | Left access request |
| l_we | input | 1 | Left write (1) or read (0) |
| l_addr | input | 13 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, one cycle after the read |
| l_int_n | output | 1 | Left interrupt, active low |
| r_en | input | 1 | Right access request |
| r_we | input | 1 | Right write (1) or read (0) |
| r_addr | input | 13 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, one cycle after the read |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The assertions check the interrupt rules on every cycle:
- raising on a write to the partner's slot;
- clearing on a read of one's own slot;
- set winning over clear;
- the idle state under reset;
- a write to one's own slot leaving the slot untouched;
- a read of the partner's slot leaving the interrupt asserted.

Data correctness needs the bench's scenarios, because it depends on history. The scenarios cover:
- read-before-write ordering;
- the right port winning a same-address write;
- aliasing of ordinary addresses;
- returned slot contents.

The bench compares these against its own model over long random mixes.

// File: rtl/dpm_pkg.sv
// Package: shared types for the dual-port mailbox unit.
// Assumes: nothing beyond standard SystemVerilog.
package dpm_pkg;
    // Classification of a single port access after address decode.
    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_MEM     = 2'd1,
        ACC_OWN_MB  = 2'd2,
        ACC_PEER_MB = 2'd3
    } acc_kind_t;
endpackage

// File: rtl/dpm_port_decode.sv
// Module: dpm_port_decode
// Sorts one port's access into ordinary storage, own mailbox or the
// partner's mailbox. Assumes the two mailboxes sit at the top two addresses.
module dpm_port_decode
    import dpm_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter bit IS_LEFT = 1'b1
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         kind
);
    localparam logic [ADDR_W-1:0] MB_RIGHT = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] MB_LEFT  = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] MB_OWN   = IS_LEFT ? MB_LEFT : MB_RIGHT;
    localparam logic [ADDR_W-1:0] MB_PEER  = IS_LEFT ? MB_RIGHT : MB_LEFT;

    // Purpose: map the address of an enabled access onto its kind.
    always_comb begin
        if (!en)                   kind = ACC_NONE;
        else if (addr == MB_OWN)   kind = ACC_OWN_MB;
        else if (addr == MB_PEER)  kind = ACC_PEER_MB;
        else                       kind = ACC_MEM;
    end
endmodule

// File: rtl/dpm_irq_flag.sv
// Module: dpm_irq_flag
// Holds one port's pending-message flag and drives the active-low line.
// Assumes set and clear are single-cycle qualifiers; set has priority.
module dpm_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);
    logic pend_q;

    // Purpose: update the pending flag; a new message beats a collection.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (set_i)  pend_q <= 1'b1;
        else if (clr_i)  pend_q <= 1'b0;
    end

    assign irq_n = ~pend_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !irq_n);  // R8
    AST_CLEAR_ON_OWN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> irq_n);  // R5
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(irq_n));  // R6
endmodule

// File: rtl/dpm_store.sv
// Module: dpm_store
// Two-port synchronous word array with registered read data.
// Assumes: reads return old contents on a same-cycle write; when both
// ports write one word together, port B's data is kept.
module dpm_store #(
    parameter int DATA_W = 16,
    parameter int AW     = 9
) (
    input  logic              clk,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [AW-1:0]     a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [AW-1:0]     b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: apply writes, port B last so it wins a collision.
    always_ff @(posedge clk) begin
        if (a_en && a_we) mem[a_addr] <= a_wdata;
        if (b_en && b_we) mem[b_addr] <= b_wdata;
    end

    // Purpose: register read data for both ports (read-before-write).
    always_ff @(posedge clk) begin
        if (a_en && !a_we) a_rdata <= mem[a_addr];
        if (b_en && !b_we) b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/dpm_mailbox_top.sv
// Module: dpm_mailbox_top
// Two CPU ports onto shared storage. The top two addresses are mailboxes
// whose accesses raise and clear the ports' active-low interrupts.
// Assumes: synchronous active-low reset; no arbitration is performed.
module dpm_mailbox_top
    import dpm_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 16,
    parameter int STORE_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_int_n,
    input  logic              r_en,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_int_n
);
    localparam logic [ADDR_W-1:0] MB_RIGHT = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] MB_LEFT  = {{(ADDR_W-1){1'b1}}, 1'b0};

    acc_kind_t l_kind, r_kind;
    logic [DATA_W-1:0] mb_l_q, mb_r_q;
    logic [DATA_W-1:0] l_mem_rd, r_mem_rd, l_mb_rd_q, r_mb_rd_q;
    logic              l_mb_sel_q, r_mb_sel_q;
    logic              set_l, clr_l, set_r, clr_r;

    dpm_port_decode #(.ADDR_W(ADDR_W), .IS_LEFT(1'b1)) u_dec_l (
        .en(l_en), .addr(l_addr), .kind(l_kind));
    dpm_port_decode #(.ADDR_W(ADDR_W), .IS_LEFT(1'b0)) u_dec_r (
        .en(r_en), .addr(r_addr), .kind(r_kind));

    dpm_store #(.DATA_W(DATA_W), .AW(STORE_AW)) u_store (
        .clk(clk),
        .a_en(l_kind == ACC_MEM), .a_we(l_we), .a_addr(l_addr[STORE_AW-1:0]),
        .a_wdata(l_wdata), .a_rdata(l_mem_rd),
        .b_en(r_kind == ACC_MEM), .b_we(r_we), .b_addr(r_addr[STORE_AW-1:0]),
        .b_wdata(r_wdata), .b_rdata(r_mem_rd));

    // Purpose: derive interrupt set/clear events from mailbox accesses.
    always_comb begin
        set_r = (l_kind == ACC_PEER_MB) && l_we;
        set_l = (r_kind == ACC_PEER_MB) && r_we;
        clr_l = (l_kind == ACC_OWN_MB)  && !l_we;
        clr_r = (r_kind == ACC_OWN_MB)  && !r_we;
    end

    // Purpose: store mailbox words; only the partner's write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mb_l_q <= '0;
            mb_r_q <= '0;
        end else begin
            if (set_l) mb_l_q <= r_wdata;
            if (set_r) mb_r_q <= l_wdata;
        end
    end

    // Purpose: capture mailbox read data and the per-port result select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_mb_sel_q <= 1'b0;
            r_mb_sel_q <= 1'b0;
            l_mb_rd_q  <= '0;
            r_mb_rd_q  <= '0;
        end else begin
            if (l_en && !l_we) begin
                l_mb_sel_q <= (l_kind != ACC_MEM);
                l_mb_rd_q  <= (l_addr == MB_LEFT) ? mb_l_q : mb_r_q;
            end
            if (r_en && !r_we) begin
                r_mb_sel_q <= (r_kind != ACC_MEM);
                r_mb_rd_q  <= (r_addr == MB_LEFT) ? mb_l_q : mb_r_q;
            end
        end
    end

    assign l_rdata = l_mb_sel_q ? l_mb_rd_q : l_mem_rd;
    assign r_rdata = r_mb_sel_q ? r_mb_rd_q : r_mem_rd;

    dpm_irq_flag u_irq_l (.clk(clk), .rst_n(rst_n), .set_i(set_l),
                          .clr_i(clr_l), .irq_n(l_int_n));
    dpm_irq_flag u_irq_r (.clk(clk), .rst_n(rst_n), .set_i(set_r),
                          .clr_i(clr_r), .irq_n(r_int_n));

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (l_int_n && r_int_n));  // R1
    AST_LEFT_WRITE_RAISES_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && l_we && l_addr == MB_RIGHT) |=> !r_int_n);  // R3
    AST_RIGHT_WRITE_RAISES_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_en && r_we && r_addr == MB_LEFT) |=> !l_int_n);  // R4
    AST_OWN_WRITE_IGNORED_L: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && l_we && l_addr == MB_LEFT && !(r_en && r_we && r_addr == MB_LEFT))
        |=> $stable(mb_l_q));  // R7
    AST_OWN_WRITE_IGNORED_R: assert property (@(posedge clk) disable iff (!rst_n)
        (r_en && r_we && r_addr == MB_RIGHT && !(l_en && l_we && l_addr == MB_RIGHT))
        |=> $stable(mb_r_q));  // R7
    AST_PEER_READ_KEEPS_R: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && !l_we && l_addr == MB_RIGHT && !r_int_n
         && !(r_en && !r_we && r_addr == MB_RIGHT)) |=> !r_int_n);  // R6
    AST_PEER_READ_KEEPS_L: assert property (@(posedge clk) disable iff (!rst_n)
        (r_en && !r_we && r_addr == MB_LEFT && !l_int_n
         && !(l_en && !l_we && l_addr == MB_LEFT)) |=> !l_int_n);  // R6
endmodule

// File: tb/tb_dpm_mailbox_top.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a behavioural model kept in bench variables.
module tb_dpm_mailbox_top;
    localparam int AW = 13;
    localparam int DW = 16;
    localparam int SAW = 9;
    localparam logic [AW-1:0] MBR = 13'h1FFF;
    localparam logic [AW-1:0] MBL = 13'h1FFE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_int_n, r_int_n;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [DW-1:0] m_mem [1 << SAW];
    logic [DW-1:0] m_mbl, m_mbr, e_lrd, e_rrd;
    logic m_fl, m_fr;

    always #10 clk = ~clk;

    dpm_mailbox_top #(.ADDR_W(AW), .DATA_W(DW), .STORE_AW(SAW)) dut (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_int_n(l_int_n),
        .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_int_n(r_int_n));

    // Expected value of a read from the model, before this cycle's writes.
    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
        if (a == MBL) return m_mbl;
        if (a == MBR) return m_mbr;
        return m_mem[a[SAW-1:0]];
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle on both ports; model update and checks.
    task automatic cyc(input string tag,
                       input logic le, input logic lw, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                       input logic re, input logic rw, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
        l_en = le; l_we = lw; l_addr = la; l_wdata = ld;
        r_en = re; r_we = rw; r_addr = ra; r_wdata = rd;
        @(posedge clk);
        e_lrd = model_read(la);
        e_rrd = model_read(ra);
        if (le && lw && la < MBL) m_mem[la[SAW-1:0]] = ld;
        if (re && rw && ra < MBL) m_mem[ra[SAW-1:0]] = rd;
        if (le && !lw && la == MBL) m_fl = 1'b0;
        if (re && !rw && ra == MBR) m_fr = 1'b0;
        if (le && lw && la == MBR) begin m_mbr = ld; m_fr = 1'b1; end
        if (re && rw && ra == MBL) begin m_mbl = rd; m_fl = 1'b1; end
        @(negedge clk);
        l_en = 0; r_en = 0;
        if (le && !lw) chk({tag, " l_rdata"}, l_rdata, e_lrd);
        if (re && !rw) chk({tag, " r_rdata"}, r_rdata, e_rrd);
        chk({tag, " l_int_n"}, {15'd0, l_int_n}, {15'd0, ~m_fl});
        chk({tag, " r_int_n"}, {15'd0, r_int_n}, {15'd0, ~m_fr});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL WATCHDOG: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_mbl = '0; m_mbr = '0; m_fl = 0; m_fr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset l_int_n", {15'd0, l_int_n}, 16'd1);
        chk("R1 reset r_int_n", {15'd0, r_int_n}, 16'd1);
        rst_n = 1'b1;

        // Fill storage so every later read has a known value.
        for (int i = 0; i < (1 << SAW); i++)
            cyc("R2 fill", 1, 1, AW'(i), DW'(i * 7 + 3), 0, 0, '0, '0);

        // R2: cross-port write then read.
        cyc("R2", 1, 1, 13'h0005, 16'hBEEF, 0, 0, '0, '0);
        cyc("R2", 0, 0, '0, '0, 1, 0, 13'h0005, '0);
        // R10: aliasing of an upper ordinary address.
        cyc("R10", 1, 1, 13'h0205, 16'h1234, 0, 0, '0, '0);
        cyc("R10", 0, 0, '0, '0, 1, 0, 13'h0005, '0);
        // R9: right wins same-address writes; read-before-write.
        cyc("R9", 1, 1, 13'h0010, 16'hAAAA, 1, 1, 13'h0010, 16'h5555);
        cyc("R9", 1, 0, 13'h0010, '0, 0, 0, '0, '0);
        cyc("R9", 1, 1, 13'h0010, 16'h7777, 1, 0, 13'h0010, '0);
        cyc("R9", 0, 0, '0, '0, 1, 0, 13'h0010, '0);
        // R3 then R6 then R5 on the right slot.
        cyc("R3", 1, 1, MBR, 16'hA5A5, 0, 0, '0, '0);
        cyc("R6", 1, 0, MBR, '0, 0, 0, '0, '0);
        cyc("R5", 0, 0, '0, '0, 1, 0, MBR, '0);
        // R4 then R6 then R5 on the left slot.
        cyc("R4", 0, 0, '0, '0, 1, 1, MBL, 16'h3C3C);
        cyc("R6", 0, 0, '0, '0, 1, 0, MBL, '0);
        cyc("R5", 1, 0, MBL, '0, 0, 0, '0, '0);
        // R7: own-slot writes ignored, then read back unchanged value.
        cyc("R7", 1, 1, MBL, 16'h1111, 1, 1, MBR, 16'h2222);
        cyc("R7", 1, 0, MBL, '0, 1, 0, MBR, '0);
        // R8: set and clear together keep the interrupt asserted.
        cyc("R8", 0, 0, '0, '0, 1, 1, MBL, 16'h0F0F);
        cyc("R8", 1, 0, MBL, '0, 1, 1, MBL, 16'hF0F0);
        cyc("R8", 1, 1, MBR, 16'h9999, 1, 0, MBR, '0);
        cyc("R8", 1, 0, MBL, '0, 1, 0, MBR, '0);

        // Random mix biased towards the mailbox addresses.
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] la, ra;
            la = ($urandom % 4 == 0) ? (($urandom % 2) ? MBL : MBR) : AW'($urandom % 13'h1FFE);
            ra = ($urandom % 4 == 0) ? (($urandom % 2) ? MBL : MBR) : AW'($urandom % 13'h1FFE);
            cyc("R2 R3 R4 R5 random", 1'($urandom), 1'($urandom), la, DW'($urandom),
                1'($urandom), 1'($urandom), ra, DW'($urandom));
        end

        // R1: reset mid-run with interrupts pending.
        cyc("R3", 1, 1, MBR, 16'h4444, 1, 1, MBL, 16'h6666);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 l_int_n after reset", {15'd0, l_int_n}, 16'd1);
        chk("R1 r_int_n after reset", {15'd0, r_int_n}, 16'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule